// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal and vertical sync, data enable, the current pixel column and line, and one-cycle strobes at frame start and at the last active pixel. It runs on the pixel clock. A frame is measured from the leading edge of sync rather than from the first active pixel, so every window is given as a start and end count on that common origin.

Software computes, per axis, the sync end (the sync width), the display start (sync width plus back porch), the display end (display start plus the active size) and the total (display end plus front porch), and presents them on the input ports together with polarity bits and a pixel-edge select. The block copies all of these into shadow registers while stopped and on the last count of every frame, so a change made mid-frame only takes effect at the next frame origin. Counters are 16 bits wide by default and cover 800x600 and larger panels.

Top module: `lcd_timing_gen`

## Requirements
- R1: While running, `xPos` counts 0 to `hTotal`-1 and wraps to 0; `yPos` advances by one each time `xPos` wraps and runs 0 to `vTotal`-1, so both are 0 in the first running cycle.
- R2: With active-high polarity, `hSync` is 1 while `xPos` < `hSyncEnd` and `vSync` is 1 while `yPos` < `vSyncEnd`; sync always begins at count 0.
- R3: With active-high polarity, `de` is 1 exactly when `hDispStart` <= `xPos` < `hDispEnd` and `vDispStart` <= `yPos` < `vDispEnd`.
- R4: `sof` is 1 for the single cycle in which `xPos` = 0 and `yPos` = 0 while running, and 0 otherwise.
- R5: `eof` is 1 for the single cycle in which `xPos` = `hDispEnd`-1 and `yPos` = `vDispEnd`-1 while running, and 0 otherwise.
- R6: `hSyncLow`, `vSyncLow` and `deLow` each invert only their own output: when set, that output is 0 while asserted and 1 while inactive, including when stopped.
- R7: All timing, polarity and edge inputs are captured only while stopped or on the last count of a frame; a change applied mid-frame has no effect until `xPos` = 0, `yPos` = 0 of the next frame.
- R8: After the first clock edge that samples `runEn` low, `hSync`, `vSync` and `de` sit at their inactive level and `sof`, `eof` are 0; from the following edge `xPos` and `yPos` are 0. The first running cycle follows the first edge that samples `runEn` high.
- R9: `pclkInv` presents the captured `pclkFall` bit (1 = launch data on the falling pixel-clock edge), captured under the same rule as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Run enable; low holds the raster at its origin |
| hSyncEnd | input | 10 | Horizontal sync width in pixels |
| hDispStart | input | 16 | First active column, counted from sync start |
| hDispEnd | input | 16 | Column after the last active one |
| hTotal | input | 16 | Pixels per line |
| vSyncEnd | input | 10 | Vertical sync width in lines |
| vDispStart | input | 16 | First active line |
| vDispEnd | input | 16 | Line after the last active one |
| vTotal | input | 16 | Lines per frame |
| hSyncLow | input | 1 | 1 makes hSync active low |
| vSyncLow | input | 1 | 1 makes vSync active low |
| deLow | input | 1 | 1 makes de active low |
| pclkFall | input | 1 | 1 selects the falling pixel-clock edge for data launch |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| xPos | output | 16 | Current column |
| yPos | output | 16 | Current line |
| sof | output | 1 | Frame start strobe |
| eof | output | 1 | Last active pixel strobe |
| pclkInv | output | 1 | Captured edge select for the panel clock pad |

## Verification
The assertions assume a sane timing set: totals of at least 2, sync ends no larger than the totals, and display start below display end with display end no larger than the total; with other values the counter bound and strobe properties are not meaningful. The stimulus uses only such sets, small enough that full frames are scanned cycle by cycle, and changes inputs mid-frame only in the scenario that checks the capture rule, always with a second valid set.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  // Strobes from the sequencing control to the counting datapath.
  typedef struct packed {
    logic run;    // raster is live
    logic clear;  // force counters to origin
    logic wrapX;  // last column of the line
    logic wrapY;  // last column of the last line
    logic load;   // capture timing inputs into shadows
  } lcdt_strb_t;

endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [CNT_W-1:0] hCnt,
  input  logic [CNT_W-1:0] vCnt,
  input  logic [CNT_W-1:0] hTotS,
  input  logic [CNT_W-1:0] vTotS,
  output lcdt_strb_t       strb
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic active;
  logic lastX;
  logic lastY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) active <= 1'b0;
    else       active <= runEn;
  end

  assign lastX = (hCnt == hTotS - ONE);
  assign lastY = (vCnt == vTotS - ONE);

  always_comb begin
    strb.run   = active;
    strb.clear = !active;
    strb.wrapX = active && lastX;
    strb.wrapY = active && lastX && lastY;
    strb.load  = !active || (lastX && lastY);
  end

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (hCnt == '0) && (vCnt == '0)) else $error("counters not cleared"); // R8

endmodule

// File: rtl/lcdt_datapath.sv
module lcdt_datapath
  import lcdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcdt_strb_t        strb,
  input  logic [SYNC_W-1:0] hSyncEnd,
  input  logic [CNT_W-1:0]  hDispStart,
  input  logic [CNT_W-1:0]  hDispEnd,
  input  logic [CNT_W-1:0]  hTotal,
  input  logic [SYNC_W-1:0] vSyncEnd,
  input  logic [CNT_W-1:0]  vDispStart,
  input  logic [CNT_W-1:0]  vDispEnd,
  input  logic [CNT_W-1:0]  vTotal,
  input  logic              hSyncLow,
  input  logic              vSyncLow,
  input  logic              deLow,
  input  logic              pclkFall,
  output logic [CNT_W-1:0]  hCnt,
  output logic [CNT_W-1:0]  vCnt,
  output logic [CNT_W-1:0]  hTotS,
  output logic [CNT_W-1:0]  vTotS,
  output logic              hSync,
  output logic              vSync,
  output logic              de,
  output logic              sof,
  output logic              eof,
  output logic              pclkInv
);

  localparam int PAD_W = CNT_W - SYNC_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SYNC_W-1:0] hSyncEndS, vSyncEndS;
  logic [CNT_W-1:0]  hDispStartS, hDispEndS, vDispStartS, vDispEndS;
  logic              hLowS, vLowS, deLowS, pclkFallS;
  logic              hOn, vOn, deOn;

  // Shadow copies of the timing set, refreshed only at safe points.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hSyncEndS   <= '0;
      hDispStartS <= '0;
      hDispEndS   <= '0;
      hTotS       <= '0;
      vSyncEndS   <= '0;
      vDispStartS <= '0;
      vDispEndS   <= '0;
      vTotS       <= '0;
      hLowS       <= 1'b0;
      vLowS       <= 1'b0;
      deLowS      <= 1'b0;
      pclkFallS   <= 1'b0;
    end else if (strb.load) begin
      hSyncEndS   <= hSyncEnd;
      hDispStartS <= hDispStart;
      hDispEndS   <= hDispEnd;
      hTotS       <= hTotal;
      vSyncEndS   <= vSyncEnd;
      vDispStartS <= vDispStart;
      vDispEndS   <= vDispEnd;
      vTotS       <= vTotal;
      hLowS       <= hSyncLow;
      vLowS       <= vSyncLow;
      deLowS      <= deLow;
      pclkFallS   <= pclkFall;
    end
  end

  // Raster counters, origin at the leading edge of sync.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.clear) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.wrapX) begin
      hCnt <= '0;
      vCnt <= strb.wrapY ? '0 : vCnt + ONE;
    end else begin
      hCnt <= hCnt + ONE;
    end
  end

  assign hOn  = strb.run && (hCnt < {{PAD_W{1'b0}}, hSyncEndS});
  assign vOn  = strb.run && (vCnt < {{PAD_W{1'b0}}, vSyncEndS});
  assign deOn = strb.run && (hCnt >= hDispStartS) && (hCnt < hDispEndS)
                         && (vCnt >= vDispStartS) && (vCnt < vDispEndS);

  assign hSync   = hOn  ^ hLowS;
  assign vSync   = vOn  ^ vLowS;
  assign de      = deOn ^ deLowS;
  assign sof     = strb.run && (hCnt == '0) && (vCnt == '0);
  assign eof     = strb.run && (hCnt == hDispEndS - ONE) && (vCnt == vDispEndS - ONE);
  assign pclkInv = pclkFallS;

  AST_X_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> hCnt < hTotS) else $error("column past total"); // R1
  AST_X_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrapX |=> hCnt == '0) else $error("no wrap to column 0"); // R1
  AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sof |=> !sof) else $error("sof wider than one cycle"); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |-> !sof && !eof) else $error("strobe while stopped"); // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.load) |=> $stable(hTotS) && $stable(hDispEndS)) else $error("shadow moved mid-frame"); // R7

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [SYNC_W-1:0] hSyncEnd,
  input  logic [CNT_W-1:0]  hDispStart,
  input  logic [CNT_W-1:0]  hDispEnd,
  input  logic [CNT_W-1:0]  hTotal,
  input  logic [SYNC_W-1:0] vSyncEnd,
  input  logic [CNT_W-1:0]  vDispStart,
  input  logic [CNT_W-1:0]  vDispEnd,
  input  logic [CNT_W-1:0]  vTotal,
  input  logic              hSyncLow,
  input  logic              vSyncLow,
  input  logic              deLow,
  input  logic              pclkFall,
  output logic              hSync,
  output logic              vSync,
  output logic              de,
  output logic [CNT_W-1:0]  xPos,
  output logic [CNT_W-1:0]  yPos,
  output logic              sof,
  output logic              eof,
  output logic              pclkInv
);

  lcdt_strb_t       strb;
  logic [CNT_W-1:0] hCnt, vCnt, hTotS, vTotS;

  lcdt_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .hCnt(hCnt), .vCnt(vCnt), .hTotS(hTotS), .vTotS(vTotS),
    .strb(strb)
  );

  lcdt_datapath #(.CNT_W(CNT_W), .SYNC_W(SYNC_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hSyncEnd(hSyncEnd), .hDispStart(hDispStart), .hDispEnd(hDispEnd), .hTotal(hTotal),
    .vSyncEnd(vSyncEnd), .vDispStart(vDispStart), .vDispEnd(vDispEnd), .vTotal(vTotal),
    .hSyncLow(hSyncLow), .vSyncLow(vSyncLow), .deLow(deLow), .pclkFall(pclkFall),
    .hCnt(hCnt), .vCnt(vCnt), .hTotS(hTotS), .vTotS(vTotS),
    .hSync(hSync), .vSync(vSync), .de(de), .sof(sof), .eof(eof), .pclkInv(pclkInv)
  );

  assign xPos = hCnt;
  assign yPos = vCnt;

endmodule

// File: tb/lcd_timing_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [9:0]  hSyncEnd = '0, vSyncEnd = '0;
  logic [15:0] hDispStart = '0, hDispEnd = '0, hTotal = '0;
  logic [15:0] vDispStart = '0, vDispEnd = '0, vTotal = '0;
  logic        hSyncLow = 1'b0, vSyncLow = 1'b0, deLow = 1'b0, pclkFall = 1'b0;
  logic        hSync, vSync, de, sof, eof, pclkInv;
  logic [15:0] xPos, yPos;

  int checks = 0;
  int errors = 0;

  // expected (captured) timing set
  int eHSE, eHDS, eHDE, eHT, eVSE, eVDS, eVDE, eVT;
  bit eHL, eVL, eDL, ePF;

  always #2.5 clk = ~clk;

  lcd_timing_gen dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .hSyncEnd(hSyncEnd), .hDispStart(hDispStart), .hDispEnd(hDispEnd), .hTotal(hTotal),
    .vSyncEnd(vSyncEnd), .vDispStart(vDispStart), .vDispEnd(vDispEnd), .vTotal(vTotal),
    .hSyncLow(hSyncLow), .vSyncLow(vSyncLow), .deLow(deLow), .pclkFall(pclkFall),
    .hSync(hSync), .vSync(vSync), .de(de), .xPos(xPos), .yPos(yPos),
    .sof(sof), .eof(eof), .pclkInv(pclkInv)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input int hse, hds, hde, ht, vse, vds, vde, vt,
                       input bit hl, vl, dl, pf);
    hSyncEnd = 10'(hse); hDispStart = 16'(hds); hDispEnd = 16'(hde); hTotal = 16'(ht);
    vSyncEnd = 10'(vse); vDispStart = 16'(vds); vDispEnd = 16'(vde); vTotal = 16'(vt);
    hSyncLow = hl; vSyncLow = vl; deLow = dl; pclkFall = pf;
  endtask

  task automatic expectFromInputs();
    eHSE = hSyncEnd; eHDS = hDispStart; eHDE = hDispEnd; eHT = hTotal;
    eVSE = vSyncEnd; eVDS = vDispStart; eVDE = vDispEnd; eVT = vTotal;
    eHL = hSyncLow; eVL = vSyncLow; eDL = deLow; ePF = pclkFall;
  endtask

  task automatic expectCycle(input int n);
    int h = n % eHT;
    int v = (n / eHT) % eVT;
    bit deOn = (h >= eHDS) && (h < eHDE) && (v >= eVDS) && (v < eVDE);
    chk("R1", "xPos", int'(xPos), h);
    chk("R1", "yPos", int'(yPos), v);
    chk("R2", "hSync", int'(hSync), int'((h < eHSE) ^ eHL));
    chk("R2", "vSync", int'(vSync), int'((v < eVSE) ^ eVL));
    chk("R3", "de", int'(de), int'(deOn ^ eDL));
    chk("R4", "sof", int'(sof), int'(h == 0 && v == 0));
    chk("R5", "eof", int'(eof), int'(h == eHDE - 1 && v == eVDE - 1));
    chk("R9", "pclkInv", int'(pclkInv), int'(ePF));
  endtask

  // R8: idle outputs at the inactive level
  task automatic checkIdle(input bit hl, vl, dl);
    chk("R8", "idle hSync", int'(hSync), int'(hl));
    chk("R8", "idle vSync", int'(vSync), int'(vl));
    chk("R8", "idle de", int'(de), int'(dl));
    chk("R8", "idle sof", int'(sof), 0);
    chk("R8", "idle eof", int'(eof), 0);
  endtask

  task automatic testReset();
    drive(2, 4, 10, 12, 1, 2, 5, 6, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle(0, 0, 0);
    chk("R8", "reset xPos", int'(xPos), 0);
    chk("R8", "reset yPos", int'(yPos), 0);
  endtask

  // R7/R9: mid-frame change held off to next frame origin; R1-R5 per cycle
  task automatic testCaptureRule();
    drive(2, 4, 10, 12, 1, 2, 5, 6, 0, 0, 0, 0);
    expectFromInputs();
    runEn = 1'b1;
    @(negedge clk);
    for (int n = 0; n < eHT * eVT; n++) begin
      expectCycle(n);
      if (n == 20) drive(3, 4, 8, 12, 2, 2, 5, 6, 0, 0, 0, 1);
      @(negedge clk);
    end
    expectFromInputs();
    for (int n = 0; n < 2 * eHT * eVT; n++) begin
      expectCycle(n);
      @(negedge clk);
    end
  endtask

  // R8: stop behaviour
  task automatic testStop();
    runEn = 1'b0;
    @(negedge clk);
    checkIdle(0, 0, 0);
    @(negedge clk);
    chk("R8", "stopped xPos", int'(xPos), 0);
    chk("R8", "stopped yPos", int'(yPos), 0);
    repeat (3) @(negedge clk);
    chk("R8", "held xPos", int'(xPos), 0);
    checkIdle(0, 0, 0);
  endtask

  // R6: independent polarity inversion, idle and running
  task automatic testPolarity();
    drive(2, 3, 9, 11, 1, 1, 4, 5, 1, 0, 1, 0);
    @(negedge clk);
    chk("R6", "idle hSync low-active", int'(hSync), 1);
    chk("R6", "idle vSync high-active", int'(vSync), 0);
    chk("R6", "idle de low-active", int'(de), 1);
    expectFromInputs();
    runEn = 1'b1;
    @(negedge clk);
    for (int n = 0; n < eHT * eVT + 5; n++) begin
      expectCycle(n);
      @(negedge clk);
    end
    runEn = 1'b0;
    drive(2, 3, 9, 11, 1, 1, 4, 5, 0, 1, 0, 0);
    repeat (2) @(negedge clk);
    checkIdle(0, 1, 0);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testCaptureRule();
    testStop();
    testPolarity();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule